// File: doc/BRIEF.md
# Two-Level Microcode/Nanocode Control Sequencer

This block steps a processor's control through short microprograms kept in two small read-only stores. The narrow store holds sequencing words: a sequencing code, a condition select, a branch target, a four-bit register number and a pointer into the wide store. The wide store holds horizontal nanowords, in which each bit drives one datapath strobe directly. Several sequencing words point at the same nanoword, so common datapath steps are stored only once.

A 16-bit opcode taken from the prefetch queue is decoded into two entry points. The sequencer first runs the effective-address routine chosen by the addressing-mode field. That routine finishes by jumping to the operation routine, whose entry was latched at decode. Condition inputs can redirect a routine. At every end-of-instruction word the sequencer gives priority to a pending interrupt and only otherwise takes the next opcode. It waits in place when neither is present.

Top module: `microNanoSeq`

## Requirements
- R1: While `rstN` is low, `microAddr` is 0, `nanoCtrl` and `regEn` are 0, and `opTake`/`irqAck` are 0. After release, the reset routine runs at addresses 0 and 1, then reaches the dispatch word at address 2 without taking an opcode.
- R2: At an end-of-instruction word with `irqPending` low and `opValid` low, `opTake` and `irqAck` stay low and `microAddr` holds its value. The dispatch word 2 is one such word, and so is the single-word routine of operation 0 at address 12.
- R3: At an end word with `irqPending` low and `opValid` high, `opTake` is high in that same cycle. For a legal opcode, the next `microAddr` is the effective-address entry chosen by `opcode[5:4]`: mode 0 gives 3, mode 1 gives 4, mode 2 gives 6 and mode 3 gives 9.
- R4: After a legal opcode is taken, the first microaddress outside the effective-address region 3..11 is the operation entry for `opcode[15:12]`: 0 gives 12, 1 gives 13, 2 gives 15, 3 gives 18, 4 gives 19 and 5 gives 21.
- R5: An opcode is illegal when `opcode[15:12]` is 6 or more, or when any reserved bit in `opcode[11:6]` or `opcode[3:0]` is set. An illegal opcode is still consumed (`opTake` high), and the next `microAddr` is the trap routine at 26.
- R6: At an end word, `irqPending` wins over `opValid`. In that case `irqAck` is high, `opTake` is low, and the next `microAddr` is 24. `irqPending` is ignored at words that are not end words, and `irqAck` and `opTake` are never high together.
- R7: Conditional words branch to their target when the selected condition input is 1, and otherwise go to the next address. Word 9 tests `cond[0]` (taken: 11, not taken: 10). Word 15 tests `cond[1]` (17 or 16). Word 21 tests `cond[2]` (23 or 22).
- R8: The nanoword outputs are registered one cycle behind the microaddress. In the cycle after `microAddr` is 24, `nanoCtrl` is 12'h241 and `regEn` is 16'h8000, because word 24 selects register 15.
- R9: `regEn` is the decoded form of the microword's 4-bit register number. It has at most one bit set, and it is zero whenever bit 0 (register write) of `nanoCtrl` is clear.
- R10: Words 4 and 6, the first words of modes 1 and 2, share one nanoword. The `nanoCtrl` values seen one cycle after each of these addresses are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opcode | input | 16 | Opcode at the head of the prefetch queue |
| opValid | input | 1 | Prefetch queue holds an opcode |
| opTake | output | 1 | Opcode consumed this cycle |
| irqPending | input | 1 | Interrupt request waiting |
| irqAck | output | 1 | Interrupt accepted this cycle |
| cond | input | 4 | Condition inputs for conditional words |
| microAddr | output | 5 | Current microaddress |
| nanoCtrl | output | 12 | Registered horizontal control bits |
| regEn | output | 16 | Registered one-hot register enables |

## Verification
Every cycle, the assertions check four things. The register enables are at most one-hot and are gated by the write bit. The two handshakes are exclusive. Every take or acknowledge lands on a legal entry or vector. The interrupt vector's nanoword appears exactly one cycle later. The bench's scenarios are needed to show the rest: the mode- and operation-dependent entry addresses, the branch direction for each condition value, holding in place at end words, ignoring interrupts mid-routine, and the sharing of one nanoword by two routines.

// File: rtl/mnsPkg.sv
package mnsPkg;
  parameter int UA_W     = 5;
  parameter int NA_W     = 4;
  parameter int NANO_W   = 12;
  parameter int NUM_REGS = 16;
  parameter int RSEL_W   = $clog2(NUM_REGS);
  parameter int COND_N   = 4;
  parameter int CSEL_W   = $clog2(COND_N);
  parameter int OPC_W    = 16;
  parameter int NUM_OPS  = 6;
  parameter int OP_LSB   = 12;
  parameter int MODE_LSB = 4;

  localparam logic [UA_W-1:0] RESET_VEC = UA_W'(0);
  localparam logic [UA_W-1:0] IRQ_VEC   = UA_W'(24);
  localparam logic [UA_W-1:0] TRAP_VEC  = UA_W'(26);

  typedef enum logic [1:0] {
    SEQ_NEXT = 2'b00,
    SEQ_COND = 2'b01,
    SEQ_OPJ  = 2'b10,
    SEQ_END  = 2'b11
  } seq_e;

  typedef struct packed {
    seq_e              seq;
    logic [CSEL_W-1:0] condSel;
    logic [UA_W-1:0]   target;
    logic [NA_W-1:0]   nanoPtr;
    logic [RSEL_W-1:0] regSel;
  } uword_t;

  typedef struct packed {
    logic [NA_W-1:0]   nanoPtr;
    logic [RSEL_W-1:0] regSel;
  } strobe_t;
endpackage

// File: rtl/mnsControl.sv
module mnsControl
  import mnsPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              opValid,
  output logic              opTake,
  input  logic              irqPending,
  output logic              irqAck,
  input  logic [COND_N-1:0] cond,
  output logic [UA_W-1:0]   microAddr,
  output strobe_t           strobe
);
  uword_t          uWordQ;
  logic [UA_W-1:0] nextAddr;
  logic [UA_W-1:0] opEntryQ;
  logic            latchOp;
  logic [1:0]      modeField;
  logic [3:0]      opField;
  logic            illegal;

  function automatic uword_t mk(seq_e s, int c, int t, int n, int r);
    uword_t w;
    w.seq     = s;
    w.condSel = CSEL_W'(c);
    w.target  = UA_W'(t);
    w.nanoPtr = NA_W'(n);
    w.regSel  = RSEL_W'(r);
    return w;
  endfunction

  // Microprogram: reset, EA routines (3..11), operations (12..23), irq, trap
  function automatic uword_t uRom(logic [UA_W-1:0] a);
    case (a)
      5'd0:    uRom = mk(SEQ_NEXT, 0, 0, 1, 0);
      5'd1:    uRom = mk(SEQ_NEXT, 0, 0, 2, 0);
      5'd2:    uRom = mk(SEQ_END,  0, 0, 0, 0);
      5'd3:    uRom = mk(SEQ_OPJ,  0, 0, 3, 0);
      5'd4:    uRom = mk(SEQ_NEXT, 0, 0, 4, 0);
      5'd5:    uRom = mk(SEQ_OPJ,  0, 0, 5, 1);
      5'd6:    uRom = mk(SEQ_NEXT, 0, 0, 4, 0);
      5'd7:    uRom = mk(SEQ_NEXT, 0, 0, 6, 0);
      5'd8:    uRom = mk(SEQ_OPJ,  0, 0, 5, 2);
      5'd9:    uRom = mk(SEQ_COND, 0, 11, 7, 0);
      5'd10:   uRom = mk(SEQ_OPJ,  0, 0, 3, 0);
      5'd11:   uRom = mk(SEQ_OPJ,  0, 0, 8, 3);
      5'd12:   uRom = mk(SEQ_END,  0, 0, 9, 0);
      5'd13:   uRom = mk(SEQ_NEXT, 0, 0, 10, 4);
      5'd14:   uRom = mk(SEQ_END,  0, 0, 9, 0);
      5'd15:   uRom = mk(SEQ_COND, 1, 17, 11, 0);
      5'd16:   uRom = mk(SEQ_END,  0, 0, 9, 0);
      5'd17:   uRom = mk(SEQ_END,  0, 0, 12, 5);
      5'd18:   uRom = mk(SEQ_END,  0, 0, 10, 6);
      5'd19:   uRom = mk(SEQ_NEXT, 0, 0, 13, 7);
      5'd20:   uRom = mk(SEQ_END,  0, 0, 9, 0);
      5'd21:   uRom = mk(SEQ_COND, 2, 23, 11, 0);
      5'd22:   uRom = mk(SEQ_NEXT, 0, 0, 14, 8);
      5'd23:   uRom = mk(SEQ_END,  0, 0, 9, 0);
      5'd24:   uRom = mk(SEQ_NEXT, 0, 0, 15, 15);
      5'd25:   uRom = mk(SEQ_END,  0, 0, 1, 0);
      5'd26:   uRom = mk(SEQ_NEXT, 0, 0, 15, 14);
      5'd27:   uRom = mk(SEQ_END,  0, 0, 2, 0);
      default: uRom = mk(SEQ_END,  0, 0, 0, 0);
    endcase
  endfunction

  function automatic logic [UA_W-1:0] eaEntry(logic [1:0] m);
    case (m)
      2'd0:    eaEntry = UA_W'(3);
      2'd1:    eaEntry = UA_W'(4);
      2'd2:    eaEntry = UA_W'(6);
      default: eaEntry = UA_W'(9);
    endcase
  endfunction

  function automatic logic [UA_W-1:0] opEntry(logic [3:0] o);
    case (o)
      4'd0:    opEntry = UA_W'(12);
      4'd1:    opEntry = UA_W'(13);
      4'd2:    opEntry = UA_W'(15);
      4'd3:    opEntry = UA_W'(18);
      4'd4:    opEntry = UA_W'(19);
      default: opEntry = UA_W'(21);
    endcase
  endfunction

  assign modeField = opcode[MODE_LSB +: 2];
  assign opField   = opcode[OP_LSB +: 4];
  assign illegal   = (int'(opField) >= NUM_OPS) || (|opcode[11:6]) || (|opcode[3:0]);

  always_comb begin
    nextAddr = microAddr + UA_W'(1);
    opTake   = 1'b0;
    irqAck   = 1'b0;
    latchOp  = 1'b0;
    case (uWordQ.seq)
      SEQ_NEXT: nextAddr = microAddr + UA_W'(1);
      SEQ_COND: if (cond[uWordQ.condSel]) nextAddr = uWordQ.target;
      SEQ_OPJ:  nextAddr = opEntryQ;
      SEQ_END: begin
        if (irqPending) begin
          irqAck   = 1'b1;
          nextAddr = IRQ_VEC;
        end else if (opValid) begin
          opTake = 1'b1;
          if (illegal) begin
            nextAddr = TRAP_VEC;
          end else begin
            nextAddr = eaEntry(modeField);
            latchOp  = 1'b1;
          end
        end else begin
          nextAddr = microAddr;
        end
      end
      default: nextAddr = microAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      microAddr <= RESET_VEC;
      uWordQ    <= uRom(RESET_VEC);
      opEntryQ  <= '0;
    end else begin
      microAddr <= nextAddr;
      uWordQ    <= uRom(nextAddr);
      if (latchOp) opEntryQ <= opEntry(opField);
    end
  end

  assign strobe.nanoPtr = uWordQ.nanoPtr;
  assign strobe.regSel  = uWordQ.regSel;
endmodule

// File: rtl/mnsNanoPath.sv
module mnsNanoPath
  import mnsPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  output logic [NANO_W-1:0]   nanoCtrl,
  output logic [NUM_REGS-1:0] regEn
);
  // bit0 regWrite, 1 aluAdd, 2 aluSub, 3 aluAnd, 4 aluOr, 5 memRead,
  // 6 memWrite, 7 addrInc, 8 pcLoad, 9 statusSave, 10 flagUpd, 11 busHold
  function automatic logic [NANO_W-1:0] nRom(logic [NA_W-1:0] p);
    case (p)
      4'd1:    nRom = NANO_W'(12'h100);
      4'd2:    nRom = NANO_W'(12'h080);
      4'd3:    nRom = NANO_W'(12'h800);
      4'd4:    nRom = NANO_W'(12'h0A0);
      4'd5:    nRom = NANO_W'(12'h021);
      4'd6:    nRom = NANO_W'(12'h002);
      4'd7:    nRom = NANO_W'(12'h400);
      4'd8:    nRom = NANO_W'(12'h003);
      4'd9:    nRom = NANO_W'(12'h180);
      4'd10:   nRom = NANO_W'(12'h005);
      4'd11:   nRom = NANO_W'(12'h402);
      4'd12:   nRom = NANO_W'(12'h009);
      4'd13:   nRom = NANO_W'(12'h011);
      4'd14:   nRom = NANO_W'(12'h041);
      4'd15:   nRom = NANO_W'(12'h241);
      default: nRom = '0;
    endcase
  endfunction

  logic [NANO_W-1:0]   nanoWord;
  logic [NUM_REGS-1:0] regDec;

  assign nanoWord = nRom(strobe.nanoPtr);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_regDec
    assign regDec[i] = nanoWord[0] && (strobe.regSel == RSEL_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nanoCtrl <= '0;
      regEn    <= '0;
    end else begin
      nanoCtrl <= nanoWord;
      regEn    <= regDec;
    end
  end
endmodule

// File: rtl/microNanoSeq.sv
module microNanoSeq
  import mnsPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [OPC_W-1:0]    opcode,
  input  logic                opValid,
  output logic                opTake,
  input  logic                irqPending,
  output logic                irqAck,
  input  logic [COND_N-1:0]   cond,
  output logic [UA_W-1:0]     microAddr,
  output logic [NANO_W-1:0]   nanoCtrl,
  output logic [NUM_REGS-1:0] regEn
);
  strobe_t strobe;

  mnsControl u_ctrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .opValid(opValid),
    .opTake(opTake), .irqPending(irqPending), .irqAck(irqAck),
    .cond(cond), .microAddr(microAddr), .strobe(strobe)
  );

  mnsNanoPath u_nano (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .nanoCtrl(nanoCtrl), .regEn(regEn)
  );
endmodule

// File: rtl/mnsChecker.sv
module mnsChecker
  import mnsPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                opTake,
  input logic                irqAck,
  input logic [UA_W-1:0]     microAddr,
  input logic [NANO_W-1:0]   nanoCtrl,
  input logic [NUM_REGS-1:0] regEn
);
  // R9
  reg_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regEn));

  // R9
  reg_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regEn != '0) |-> nanoCtrl[0]);

  // R6
  handshake_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(opTake && irqAck));

  // R6
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> (microAddr == IRQ_VEC));

  // R3
  take_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    opTake |=> (microAddr == UA_W'(3) || microAddr == UA_W'(4) ||
                microAddr == UA_W'(6) || microAddr == UA_W'(9) ||
                microAddr == TRAP_VEC));

  // R8
  nano_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (microAddr == IRQ_VEC) |=> (nanoCtrl == NANO_W'(12'h241)));
endmodule

bind microNanoSeq mnsChecker u_chk (
  .clk(clk), .rstN(rstN), .opTake(opTake), .irqAck(irqAck),
  .microAddr(microAddr), .nanoCtrl(nanoCtrl), .regEn(regEn)
);

// File: tb/sim_microNanoSeq.sv
module sim_microNanoSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opcode = '0;
  logic        opValid = 1'b0;
  logic        opTake;
  logic        irqPending = 1'b0;
  logic        irqAck;
  logic [3:0]  cond = '0;
  logic [4:0]  microAddr;
  logic [11:0] nanoCtrl;
  logic [15:0] regEn;

  always #5 clk = ~clk;

  microNanoSeq u0 (
    .clk(clk), .rstN(rstN), .opcode(opcode), .opValid(opValid),
    .opTake(opTake), .irqPending(irqPending), .irqAck(irqAck),
    .cond(cond), .microAddr(microAddr), .nanoCtrl(nanoCtrl), .regEn(regEn)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eaOf(input logic [15:0] o);
    case (o[5:4])
      2'd0: return 3;
      2'd1: return 4;
      2'd2: return 6;
      default: return 9;
    endcase
  endfunction

  function automatic int opOf(input logic [15:0] o);
    case (o[15:12])
      4'd0: return 12;
      4'd1: return 13;
      4'd2: return 15;
      4'd3: return 18;
      4'd4: return 19;
      default: return 21;
    endcase
  endfunction

  function automatic bit badOp(input logic [15:0] o);
    return (o[15:12] >= 4'd6) || (o[11:6] != 0) || (o[3:0] != 0);
  endfunction

  bit          pTake = 0, pAck = 0, pendOp = 0, seen4 = 0, seen6 = 0;
  int          pAddr = 0, expOp = 0;
  logic [15:0] pOpc = '0;
  logic [3:0]  pCond = '0;
  logic [11:0] n4 = '0, n6 = '0;

  task automatic step(input bit v, input logic [15:0] opc, input bit irq, input logic [3:0] c);
    int cur;
    @(negedge clk);
    cur = int'(microAddr);
    if (pAck) chk(cur == 24, "R6 irq vector", cur, 24);
    else if (pTake) begin
      if (badOp(pOpc)) chk(cur == 26, "R5 trap vector", cur, 26);
      else begin
        chk(cur == eaOf(pOpc), "R3 ea entry", cur, eaOf(pOpc));
        pendOp = 1;
        expOp  = opOf(pOpc);
      end
    end else if (pendOp && (cur < 3 || cur > 11)) begin
      chk(cur == expOp, "R4 op entry", cur, expOp);
      pendOp = 0;
    end
    if (pAddr == 9)  chk(cur == (pCond[0] ? 11 : 10), "R7 word9", cur, pCond[0] ? 11 : 10);
    if (pAddr == 15) chk(cur == (pCond[1] ? 17 : 16), "R7 word15", cur, pCond[1] ? 17 : 16);
    if (pAddr == 21) chk(cur == (pCond[2] ? 23 : 22), "R7 word21", cur, pCond[2] ? 23 : 22);
    if (pAddr == 24) begin
      chk(nanoCtrl == 12'h241, "R8 nano", int'(nanoCtrl), 'h241);
      chk(regEn == 16'h8000, "R8 regEn", int'(regEn), 'h8000);
    end
    if (pAddr == 4) begin n4 = nanoCtrl; seen4 = 1; end
    if (pAddr == 6) begin n6 = nanoCtrl; seen6 = 1; end
    chk($countones(regEn) <= 1, "R9 onehot", int'(regEn), 0);
    chk(regEn == 0 || nanoCtrl[0], "R9 gated", int'(nanoCtrl), 1);
    opValid = v; opcode = opc; irqPending = irq; cond = c;
    #1;
    chk(!(opTake && irqAck), "R6 exclusive", int'({opTake, irqAck}), 0);
    pTake = opTake; pAck = irqAck; pAddr = int'(microAddr); pOpc = opc; pCond = c;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    opValid = 1'b1; irqPending = 1'b1;
    repeat (3) begin
      @(negedge clk);
      // R1 reset state
      chk(microAddr == 0, "R1 addr", int'(microAddr), 0);
      chk(nanoCtrl == 0 && regEn == 0, "R1 nano", int'(nanoCtrl), 0);
      chk(!opTake && !irqAck, "R1 handshake", int'({opTake, irqAck}), 0);
    end
    opValid = 1'b0; irqPending = 1'b0;
    rstN = 1'b1;
    repeat (5) step(0, 16'h0000, 0, 4'h0);
    chk(microAddr == 2, "R1 dispatch", int'(microAddr), 2);
    chk(!opTake, "R2 no take", int'(opTake), 0);
    step(1, 16'h1010, 1, 4'h0);              // R6 irq beats opcode
    chk(irqAck && !opTake, "R6 priority", int'({irqAck, opTake}), 2);
    repeat (3) step(0, 16'h0000, 0, 4'h0);
    step(1, 16'h0000, 0, 4'h0);              // op0, mode0
    repeat (5) step(0, 16'h0000, 0, 4'h0);
    chk(microAddr == 12, "R2 hold at end word", int'(microAddr), 12);
    step(1, 16'h5030, 0, 4'h0);              // op5 mode3
    step(0, 16'h0000, 1, 4'h1);              // at word 9, irq mid-routine
    chk(!irqAck, "R6 ignored mid-routine", int'(irqAck), 0);
    repeat (6) step(0, 16'h0000, 0, 4'h4);
    step(1, 16'h7000, 0, 4'h0);              // R5 illegal op field
    repeat (4) step(0, 16'h0000, 0, 4'h0);
    step(1, 16'h2001, 0, 4'h0);              // R5 reserved bit set
    repeat (4) step(0, 16'h0000, 0, 4'h0);
    step(1, 16'h1010, 0, 4'h0);              // mode1 visits word 4
    repeat (6) step(0, 16'h0000, 0, 4'h0);
    step(1, 16'h1020, 0, 4'h0);              // mode2 visits word 6
    repeat (6) step(0, 16'h0000, 0, 4'h0);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] o;
      o = '0;
      o[15:12] = 4'($urandom % 8);
      o[5:4]   = 2'($urandom % 4);
      if ($urandom % 16 == 0) o[3:0] = 4'($urandom);
      step(($urandom % 10) < 7, o, ($urandom % 8) == 0, 4'($urandom));
    end
    step(0, 16'h0000, 0, 4'h0);
    // R10 shared nanoword
    chk(seen4 && seen6 && n4 == n6, "R10 shared nanoword", int'(n6), int'(n4));
    finishRun();
  end
endmodule